// File: doc/BRIEF.md
# Three-Channel Half-Bridge Gate Controller

This block turns two command bits per half-bridge channel into a high-side gate enable and a low-side gate enable. Each channel can drive its output high, drive it low, or leave it floating. A channel may be tied to one of two shared PWM inputs, and that input then gates whichever switch is commanded. A global enable, produced elsewhere from the operating mode and the fault logic, removes drive from every channel at once.

Three protections sit between the command and the gates. First, the two switches of a channel are never on together. Second, after the high-side switch of a channel stops conducting, its low-side switch waits a programmable number of clock cycles before it may turn on. Third, an overcurrent input turns its channel off, and the channel stays off until the command bits are written again.

Top module: `hbridge_gate`

## Requirements
- R1: Command pair (hs,ls) per channel: 10 turns on the high-side gate only, 01 turns on the low-side gate only, and both 00 and 11 leave both gates off (high impedance).
- R2: For every channel, `gate_hs[i]` and `gate_ls[i]` are never 1 in the same cycle.
- R3: When `pwm_en[i]` is 1, a commanded gate of channel i is on only while `pwm_in[pwm_sel[i]]` is 1 (`pwm_sel[i]`=0 picks `pwm_in[0]`, 1 picks `pwm_in[1]`). When `pwm_en[i]` is 0, the PWM inputs have no effect on that channel.
- R4: While `en_global` is 0, all gates of all channels are off in that same cycle.
- R5: After reset, every command pair is 00, every overcurrent latch is clear and all gates are off.
- R6: A cycle with `wr_en`=1 loads all channels' command pairs from `wr_hs`/`wr_ls` together. With `wr_en`=0 the stored commands do not change.
- R7: After a cycle in which `gate_hs[i]` was 1, `gate_ls[i]` stays 0 for the next `dead_time` cycles. With `dead_time`=0 the low side may turn on in the first cycle after the high side turns off.
- R8: `oc[i]`=1 turns channel i off in the same cycle and latches it off. The latch clears on the next edge with `wr_en`=1 and `oc[i]`=0. If `oc[i]` and `wr_en` arrive in the same cycle, `oc[i]` wins.
- R9: A write takes effect on the gates from the cycle after the edge that samples `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_global | input | 1 | Global drive enable; 0 forces every gate off |
| wr_en | input | 1 | Command write strobe |
| wr_hs | input | NCH | High-side command bits to write |
| wr_ls | input | NCH | Low-side command bits to write |
| pwm_en | input | NCH | Per-channel PWM gating enable |
| pwm_sel | input | NCH | Per-channel PWM input select |
| pwm_in | input | 2 | The two shared PWM inputs |
| oc | input | NCH | Per-channel overcurrent indication |
| dead_time | input | DTW | Dead time in clock cycles from high side off to low side on |
| gate_hs | output | NCH | High-side gate enables |
| gate_ls | output | NCH | Low-side gate enables |

## Verification
An overcurrent event and a command rewrite can meet in one cycle, and the outcome decides whether a faulted channel comes back. The bench raises `oc` on a channel in the same cycle as a write that would turn the channel on, then checks that the channel stays off afterwards. It then repeats the write with `oc` low and checks that the channel turns on. The random phase also sets both inputs together at a low rate, and a bench model that gives the overcurrent input priority judges every cycle.

// File: rtl/hbridge_gate.sv
module hbridge_gate #(
  parameter int NCH = 3,
  parameter int DTW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_global,
  input  logic           wr_en,
  input  logic [NCH-1:0] wr_hs,
  input  logic [NCH-1:0] wr_ls,
  input  logic [NCH-1:0] pwm_en,
  input  logic [NCH-1:0] pwm_sel,
  input  logic [1:0]     pwm_in,
  input  logic [NCH-1:0] oc,
  input  logic [DTW-1:0] dead_time,
  output logic [NCH-1:0] gate_hs,
  output logic [NCH-1:0] gate_ls
);

  logic [NCH-1:0] cmd_hs, cmd_ls, oc_lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_hs <= '0;
      cmd_ls <= '0;
    end else if (wr_en) begin
      cmd_hs <= wr_hs;
      cmd_ls <= wr_ls;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) oc_lat <= '0;
    else        oc_lat <= oc | (oc_lat & ~{NCH{wr_en}});

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DTW-1:0] dt_cnt;
    logic           pwm_ok, allow;

    assign pwm_ok     = ~pwm_en[i] | pwm_in[pwm_sel[i]];
    assign allow      = en_global & ~oc[i] & ~oc_lat[i] & pwm_ok;
    assign gate_hs[i] = allow & cmd_hs[i] & ~cmd_ls[i];
    assign gate_ls[i] = allow & cmd_ls[i] & ~cmd_hs[i] & (dt_cnt == '0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               dt_cnt <= '0;
      else if (gate_hs[i])      dt_cnt <= dead_time;
      else if (dt_cnt != '0)    dt_cnt <= dt_cnt - 1'b1;
  end

endmodule

// File: rtl/hbridge_gate_chk.sv
module hbridge_gate_chk #(
  parameter int NCH = 3,
  parameter int DTW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_global,
  input logic [NCH-1:0] pwm_en,
  input logic [NCH-1:0] pwm_sel,
  input logic [1:0]     pwm_in,
  input logic [NCH-1:0] oc,
  input logic [DTW-1:0] dead_time,
  input logic [NCH-1:0] cmd_hs,
  input logic [NCH-1:0] cmd_ls,
  input logic [NCH-1:0] gate_hs,
  input logic [NCH-1:0] gate_ls
);

  localparam int CW = DTW + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  p_global_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_global |-> (gate_hs == '0 && gate_ls == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic [CW-1:0] since_hs;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             since_hs <= CMAX;
      else if (gate_hs[i])    since_hs <= '0;
      else if (since_hs != CMAX) since_hs <= since_hs + 1'b1;

    p_no_shoot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hs[i] && gate_ls[i]));

    p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hs[i] == cmd_ls[i]) |-> (!gate_hs[i] && !gate_ls[i]));

    p_pwm_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en[i] && !pwm_in[pwm_sel[i]]) |-> (!gate_hs[i] && !gate_ls[i]));

    p_oc_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      oc[i] |=> (!gate_hs[i] && !gate_ls[i]));

    p_dead_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gate_ls[i] |-> (since_hs >= {1'b0, dead_time}));
  end

endmodule

bind hbridge_gate hbridge_gate_chk #(.NCH(NCH), .DTW(DTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_global(en_global), .pwm_en(pwm_en),
  .pwm_sel(pwm_sel), .pwm_in(pwm_in), .oc(oc), .dead_time(dead_time),
  .cmd_hs(cmd_hs), .cmd_ls(cmd_ls), .gate_hs(gate_hs), .gate_ls(gate_ls)
);

// File: tb/tb_hbridge_gate.sv
module tb_hbridge_gate;
  localparam int NCH = 3;
  localparam int DTW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_global = 1'b0, wr_en = 1'b0;
  logic [NCH-1:0] wr_hs = '0, wr_ls = '0, pwm_en = '0, pwm_sel = '0, oc = '0;
  logic [1:0] pwm_in = '0;
  logic [DTW-1:0] dead_time = '0;
  logic [NCH-1:0] gate_hs, gate_ls;

  int n_chk = 0, n_fail = 0;

  logic [NCH-1:0] m_hs = '0, m_ls = '0, m_oc = '0;
  int m_dt [NCH] = '{default: 0};

  always #4 clk = ~clk;

  hbridge_gate #(.NCH(NCH), .DTW(DTW)) dut (.*);

  function automatic logic [2*NCH-1:0] expect_gates();
    logic [NCH-1:0] eh, el;
    for (int i = 0; i < NCH; i++) begin
      logic g, a;
      g = !pwm_en[i] || pwm_in[pwm_sel[i]];
      a = en_global && !oc[i] && !m_oc[i] && g;
      eh[i] = a && m_hs[i] && !m_ls[i];
      el[i] = a && m_ls[i] && !m_hs[i] && (m_dt[i] == 0);
    end
    return {eh, el};
  endfunction

  function automatic string pick_tag();
    if ((oc | m_oc) != '0) return "R8";
    if (!en_global)        return "R4";
    if (pwm_en != '0)      return "R3";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [NCH-1:0] eh, input logic [NCH-1:0] el);
    n_chk++;
    if (gate_hs !== eh || gate_ls !== el) begin
      n_fail++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b at %0t",
               tag, gate_hs, gate_ls, eh, el, $time);
    end
  endtask

  task automatic model_check(input string tag);
    logic [2*NCH-1:0] e;
    e = expect_gates();
    check(tag, e[2*NCH-1:NCH], e[NCH-1:0]);
  endtask

  // one cycle: inputs already driven after negedge; check, then advance model at edge
  task automatic cycle(input string tag);
    logic [2*NCH-1:0] e;
    #1;
    if (tag != "") model_check(tag);
    e = expect_gates();
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      if (e[NCH+i])        m_dt[i] = int'(dead_time);
      else if (m_dt[i] > 0) m_dt[i] = m_dt[i] - 1;
    end
    m_oc = oc | (m_oc & ~{NCH{wr_en}});
    if (wr_en) begin m_hs = wr_hs; m_ls = wr_ls; end
    @(negedge clk);
    wr_en = 1'b0;
    oc = '0;
  endtask

  task automatic write_cmd(input logic [NCH-1:0] h, input logic [NCH-1:0] l, input string tag);
    wr_hs = h; wr_ls = l; wr_en = 1'b1;
    cycle(tag);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    dead_time = 3'd3;
    en_global = 1'b1;
    pwm_in = 2'b11;
    repeat (3) @(negedge clk);
    // R5: reset state, enable high and PWM high but nothing commanded
    #1 check("R5", '0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R5", '0, '0);

    // R9/R6: write HS on all channels; off before the edge, on after
    wr_hs = 3'b111; wr_ls = 3'b000; wr_en = 1'b1;
    #1 check("R9", '0, '0);
    cycle("");
    #1 check("R6", 3'b111, 3'b000);
    wr_hs = 3'b000; wr_ls = 3'b111;
    cycle("");
    #1 check("R6", 3'b111, 3'b000); // no write strobe, commands hold

    // R1: 11 and 00 codes float, 10 drives high, 01 drives low
    write_cmd(3'b110, 3'b100, "R1");
    #1 check("R1", 3'b010, 3'b000);

    // R7: channel 1 HS->LS with dead_time 3
    write_cmd(3'b000, 3'b010, "R7");
    for (int k = 0; k < 3; k++) begin
      #1 check("R7", 3'b000, 3'b000);
      cycle("");
    end
    #1 check("R7", 3'b000, 3'b010);

    // R3: PWM gating via pwm_in[1] on channel 1
    pwm_en = 3'b010; pwm_sel = 3'b010; pwm_in = 2'b01;
    #1 check("R3", 3'b000, 3'b000);
    pwm_in = 2'b10;
    #1 check("R3", 3'b000, 3'b010);
    pwm_en = 3'b000; pwm_in = 2'b00;
    #1 check("R3", 3'b000, 3'b010);

    // R4: global disable
    en_global = 1'b0;
    #1 check("R4", 3'b000, 3'b000);
    en_global = 1'b1;
    cycle("R4");

    // R8: overcurrent together with a write, then a clean write
    write_cmd(3'b001, 3'b000, "R8");
    #1 check("R8", 3'b001, 3'b000);
    oc = 3'b001; wr_en = 1'b1; wr_hs = 3'b001; wr_ls = 3'b000;
    #1 check("R8", 3'b000, 3'b000);
    cycle("");
    #1 check("R8", 3'b000, 3'b000);
    cycle("");
    #1 check("R8", 3'b000, 3'b000);
    write_cmd(3'b001, 3'b000, "R8");
    #1 check("R8", 3'b001, 3'b000);

    // R7 with dead_time 0: low side on in the first cycle after high side off
    en_global = 1'b0;
    repeat (10) cycle("R4");
    dead_time = 3'd0;
    en_global = 1'b1;
    write_cmd(3'b001, 3'b000, "R7");
    write_cmd(3'b000, 3'b001, "R7");
    #1 check("R7", 3'b000, 3'b001);

    // random phase
    en_global = 1'b0;
    repeat (10) cycle("R4");
    dead_time = 3'd2;
    for (int n = 0; n < 3000; n++) begin
      en_global = ($urandom_range(0, 15) != 0);
      pwm_en    = NCH'($urandom);
      pwm_sel   = NCH'($urandom);
      pwm_in    = 2'($urandom);
      oc        = ($urandom_range(0, 19) == 0) ? NCH'($urandom) : '0;
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1; wr_hs = NCH'($urandom); wr_ls = NCH'($urandom);
      end
      #1;
      n_chk++;
      if ((gate_hs & gate_ls) != '0) begin
        n_fail++;
        $display("FAIL R2: overlap=%b expected 000", gate_hs & gate_ls);
      end
      cycle(pick_tag());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule